// File: doc/BRIEF.md
# Beam Rate Limit Arbiter

This block turns latched equipment-fault inputs into a registered maximum pulse-rate code for two beams, a primary beam and a secondary beam. A bank of algorithm units each looks at its own group of fault inputs and proposes a ceiling. The lowest proposal across all units becomes the algorithm limit. The granted rate of each beam is the lower of this limit and an operator-requested rate. Fault inputs are held by sticky latches. A latch bit is released only by a clear strobe that arrives while its raw input is inactive.

A stopper-status input selects the operating mode with no operator action. When the isolating stoppers are in, the primary beam alone is limited and the interrupt-unit fault has no effect. When they are out, both beams are limited, and a latched interrupt-unit fault drives both rates to zero. With automatic recovery enabled, each beam climbs back to its requested rate as soon as the faults clear. Without it, a rate can only rise when a new request is loaded.

Top module: `rate_limit_arbiter`

## Requirements
- R1: A fault bit seen high on any clock edge stays in effect after its raw input falls, until it is cleared.
- R2: Rates use a 3-bit code in which 0 means no beam and 7 is the highest rate. Within a unit, fault bit j caps that unit's proposal at code j, and a unit with no active fault proposes 7. Fault bit j of unit u is at index u*4+j of the fault input. The algorithm limit is the lowest proposal over all units.
- R3: A cycle with the load strobe high sets each beam's rate to the lower of its request and its current limit.
- R4: With the stoppers inserted (stopper input = 1), the primary beam is capped by the algorithm limit, while the secondary beam follows its request and is not capped.
- R5: With the stoppers inserted, the interrupt-unit fault changes neither rate.
- R6: With the stoppers withdrawn (stopper input = 0), an interrupt-unit fault drives both rates to 0, and the algorithm limit caps both beams. A latched interrupt fault takes effect on the edge after the stoppers are withdrawn.
- R7: With automatic recovery set, each rate returns to its requested value on the edge after the last fault latch clears.
- R8: With automatic recovery clear and no load strobe, no rate rises.
- R9: A new fault lowers the output rate on the first clock edge at which the fault input is high.
- R10: After reset, both rates are 0 and all fault latches are empty.
- R11: A clear strobe leaves a fault bit set if its raw input is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_raw | input | 16 | Raw device faults; bit u*4+j is fault j of unit u |
| intr_fault_raw | input | 1 | Raw interrupt-unit fault |
| fault_clr | input | 1 | Clear strobe for all fault latches |
| stopper_in | input | 1 | 1 = isolating stoppers inserted |
| auto_recover | input | 1 | 1 = rates rise automatically when faults clear |
| req_load | input | 1 | Strobe that loads the requested rates |
| req_primary | input | 3 | Requested rate code for the primary beam |
| req_secondary | input | 3 | Requested rate code for the secondary beam |
| rate_primary | output | 3 | Granted rate code for the primary beam |
| rate_secondary | output | 3 | Granted rate code for the secondary beam |

## Verification
A latch bit that is lost or stuck shows at the rate outputs within one edge. It appears either as a rate that recovers while a fault is still asserted or as a rate that never returns to the request after a clear. A mode decode that is wrong shows in the secondary rate during isolation, or in an interrupt fault that fails to zero both beams on the edge after the stoppers are withdrawn. A recovery register that rises without permission shows as a code above the previous one on the very next edge.

// File: rtl/rla_pkg.sv
// Shared rate code type and helpers for the beam rate limit arbiter.
// Assumes: code 0 = no beam; a larger code means a higher allowed rate.
package rla_pkg;
    localparam int RATE_W = 3;
    typedef logic [RATE_W-1:0] rate_t;
    localparam rate_t RATE_MAX = '1;
    localparam rate_t RATE_OFF = '0;

    // Lower of two rate codes (plain unsigned compare)
    function automatic rate_t rate_min(input rate_t a, input rate_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/rla_fault_latch.sv
// Sticky fault latch bank. The effective fault is the raw input OR the held bit,
// so a new fault is seen in the same cycle. A held bit drops only on a clear
// strobe while its raw input is low. Assumes inputs are already synchronous.
module rla_fault_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic         clr,
    output logic [W-1:0] eff
);
    logic [W-1:0] held;

    // Capture raw faults; clear held bits only when the strobe is present
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= raw | (held & ~{W{clr}});
    end

    // Effective fault is live raw input or remembered fault
    always_comb eff = raw | held;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((held & $past(held)) == $past(held)));            // R1
    AST_CLEAR_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((held & $past(raw)) == $past(raw)));                // R11
endmodule

// File: rtl/rla_unit.sv
// One algorithm unit: proposes a ceiling from its own effective faults.
// Fault bit j caps the proposal at code j; no active fault proposes RATE_MAX.
// Assumes NF < 2**RATE_W so every index fits in a rate code.
module rla_unit
    import rla_pkg::*;
#(
    parameter int NF = 4
) (
    input  logic [NF-1:0] fault,
    output rate_t         proposal
);
    // Lowest-index active fault wins (scan high to low, last hit is lowest)
    always_comb begin
        proposal = RATE_MAX;
        for (int j = NF - 1; j >= 0; j--) begin
            if (fault[j]) proposal = rate_t'(j);
        end
    end
endmodule

// File: rtl/rla_grant.sv
// Granted-rate register for one beam. Drops at once to min(request, limit);
// rises only when raising is permitted (automatic recovery or a load strobe).
module rla_grant
    import rla_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rate_t req,
    input  rate_t limit,
    input  logic  raise_ok,
    output rate_t granted
);
    rate_t target;

    // Target is the requested rate clipped by the limit
    always_comb target = rate_min(req, limit);

    // Update the grant; without permission it may only fall
    always_ff @(posedge clk) begin
        if (!rst_n)        granted <= RATE_OFF;
        else if (raise_ok) granted <= target;
        else               granted <= rate_min(granted, target);
    end

    AST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !raise_ok |=> granted <= $past(granted));                    // R8
    AST_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> granted <= $past(limit));                           // R9
endmodule

// File: rtl/rate_limit_arbiter.sv
// Top: latches device and interrupt faults, lets NU units propose ceilings,
// keeps the lowest, applies the stopper-dependent mode rules and registers
// one granted rate per beam. All outputs change one edge after an input change.
module rate_limit_arbiter
    import rla_pkg::*;
#(
    parameter int NU = 4,
    parameter int NF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NU*NF-1:0] fault_raw,
    input  logic             intr_fault_raw,
    input  logic             fault_clr,
    input  logic             stopper_in,
    input  logic             auto_recover,
    input  logic             req_load,
    input  logic [RATE_W-1:0] req_primary,
    input  logic [RATE_W-1:0] req_secondary,
    output logic [RATE_W-1:0] rate_primary,
    output logic [RATE_W-1:0] rate_secondary
);
    localparam int NBITS = NU * NF;

    logic [NBITS-1:0] fault_eff;
    logic             intr_eff;
    rate_t            proposal [NU];
    rate_t            chain    [NU+1];
    rate_t            algo_min;
    logic             intr_active;
    rate_t            lim_p, lim_s;
    logic             raise_ok;

    rla_fault_latch #(.W(NBITS)) u_dev_latch (
        .clk(clk), .rst_n(rst_n), .raw(fault_raw), .clr(fault_clr), .eff(fault_eff));

    rla_fault_latch #(.W(1)) u_intr_latch (
        .clk(clk), .rst_n(rst_n), .raw(intr_fault_raw), .clr(fault_clr), .eff(intr_eff));

    // Minimum chain over all unit proposals
    assign chain[0] = RATE_MAX;
    generate
        for (genvar u = 0; u < NU; u++) begin : g_unit
            rla_unit #(.NF(NF)) u_unit (
                .fault(fault_eff[u*NF +: NF]), .proposal(proposal[u]));
            assign chain[u+1] = rate_min(chain[u], proposal[u]);
        end
    endgenerate
    assign algo_min = chain[NU];

    // Mode rules: interrupt fault counts only with stoppers withdrawn;
    // the secondary beam is limited only with stoppers withdrawn
    always_comb begin
        intr_active = intr_eff & ~stopper_in;
        lim_p       = intr_active ? RATE_OFF : algo_min;
        lim_s       = stopper_in ? RATE_MAX : lim_p;
        raise_ok    = auto_recover | req_load;
    end

    rla_grant u_grant_p (
        .clk(clk), .rst_n(rst_n), .req(req_primary), .limit(lim_p),
        .raise_ok(raise_ok), .granted(rate_primary));

    rla_grant u_grant_s (
        .clk(clk), .rst_n(rst_n), .req(req_secondary), .limit(lim_s),
        .raise_ok(raise_ok), .granted(rate_secondary));

    AST_SHARED_INTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopper_in && intr_eff) |=> (rate_primary == '0 && rate_secondary == '0)); // R6
    AST_ISO_SECONDARY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (stopper_in && raise_ok) |=> rate_secondary == $past(req_secondary));      // R4
    AST_PRIMARY_UNDER_ALGO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rate_primary <= $past(algo_min));                                // R2
endmodule

// File: tb/rate_limit_arbiter_test.sv
module rate_limit_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fault_raw = '0;
    logic        intr_fault_raw = 1'b0;
    logic        fault_clr = 1'b0;
    logic        stopper_in = 1'b0;
    logic        auto_recover = 1'b0;
    logic        req_load = 1'b0;
    logic [2:0]  req_primary = 3'd5;
    logic [2:0]  req_secondary = 3'd6;
    logic [2:0]  rate_primary, rate_secondary;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_limit_arbiter uut (
        .clk(clk), .rst_n(rst_n), .fault_raw(fault_raw), .intr_fault_raw(intr_fault_raw),
        .fault_clr(fault_clr), .stopper_in(stopper_in), .auto_recover(auto_recover),
        .req_load(req_load), .req_primary(req_primary), .req_secondary(req_secondary),
        .rate_primary(rate_primary), .rate_secondary(rate_secondary));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [2:0] p, input logic [2:0] s);
        checks++;
        if (rate_primary !== p || rate_secondary !== s) begin
            fails++;
            $display("FAIL %s: got p=%0d s=%0d expected p=%0d s=%0d",
                     req, rate_primary, rate_secondary, p, s);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        check("R10 reset", 3'd0, 3'd0);
        rst_n = 1'b1; tick();
        check("R8 no rise without load after reset", 3'd0, 3'd0);
    endtask

    task automatic t_load();
        req_load = 1'b1; tick(); req_load = 1'b0;
        check("R3 load request", 3'd5, 3'd6);
    endtask

    task automatic t_latch();
        fault_raw[9] = 1'b1; tick();          // unit2 fault1 -> cap 1
        check("R9 R2 R6 one-edge drop both beams", 3'd1, 3'd1);
        fault_raw[9] = 1'b0; tick(); tick();
        check("R1 latched after raw falls", 3'd1, 3'd1);
        fault_raw[3] = 1'b1; fault_raw[14] = 1'b1; tick();
        fault_raw[3] = 1'b0; fault_raw[14] = 1'b0; tick();
        check("R2 lowest proposal kept", 3'd1, 3'd1);
    endtask

    task automatic t_clear();
        fault_raw[9] = 1'b1; fault_clr = 1'b1; tick();
        fault_clr = 1'b0; fault_raw[9] = 1'b0; tick(); tick();
        check("R11 clear while raw active keeps fault", 3'd1, 3'd1);
        fault_clr = 1'b1; tick(); fault_clr = 1'b0; tick(); tick();
        check("R8 no recovery without auto", 3'd1, 3'd1);
        req_load = 1'b1; tick(); req_load = 1'b0;
        check("R3 reload restores request", 3'd5, 3'd6);
    endtask

    task automatic t_auto();
        auto_recover = 1'b1;
        fault_raw[4] = 1'b1; tick();          // unit1 fault0 -> cap 0
        check("R2 cap zero", 3'd0, 3'd0);
        fault_raw[4] = 1'b0; fault_clr = 1'b1; tick();
        fault_clr = 1'b0; tick();
        check("R7 automatic recovery", 3'd5, 3'd6);
    endtask

    task automatic t_modes();
        stopper_in = 1'b1; tick();
        check("R4 isolated no fault", 3'd5, 3'd6);
        fault_raw[2] = 1'b1; tick(); fault_raw[2] = 1'b0;   // unit0 fault2 -> cap 2
        check("R4 isolated primary only", 3'd2, 3'd6);
        intr_fault_raw = 1'b1; tick(); intr_fault_raw = 1'b0; tick();
        check("R5 interrupt fault ignored", 3'd2, 3'd6);
        stopper_in = 1'b0; tick();
        check("R6 shared mode interrupt zeroes both", 3'd0, 3'd0);
        fault_clr = 1'b1; tick(); fault_clr = 1'b0; tick();
        check("R7 recovery after all cleared", 3'd5, 3'd6);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_load();
        t_latch();
        t_clear();
        t_auto();
        t_modes();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule